// File: doc/BRIEF.md
# Two-Phase Latch Modulo-Seven Counter

This block counts from 0 up to 6 and then returns to 0, so it divides its phase cycle rate by seven. Its state sits in a row of toggle cells. Each cell holds one bit in a pair of level-sensitive latches. The first latch is open while phase one is high, and the second latch is open while phase two is high. The two phases must never overlap. A cell takes a high-true toggle request and a low-true clear, and the clear wins when both are active. A thin layer of gates forms the toggle request for every bit from the count enable and the current count.

The surrounding logic supplies both phases with a dead gap between them. The inputs are sampled when phase one closes, and the outputs settle while phase two is open. A low clear forces the count to zero on the next full phase cycle, whatever the enable does. The width parameter defaults to three bits. The sequence then wraps one code below all-ones, which gives the divide-by-seven behaviour.

Top module: `mod7_twophase_ctr`

## Requirements
- R1: Inside each cell, a low clear overrides a high toggle request, and the cell's bit becomes 0.
- R2: With clear_n high and count_en high, the count steps 0,1,2,3,4,5,6 and then returns to 0, one step per full phase cycle.
- R3: With clear_n high and count_en low, the count keeps its value.
- R4: A low clear_n gives a count of 000 after that phase cycle, whether count_en is high or low.
- R5: The outputs change only while ph2 is high. After a ph1 pulse, and before the following ph2 pulse, q still shows the previous count.
- R6: Code 7 (q = 111) never appears once a clear has been applied.
- R7: clear_n and count_en are sampled when ph1 falls. A change to either input after that point and before ph2 has no effect on the current step.
- R8: q[0] is the least significant bit and q[2] is the most significant bit, so the first step from zero gives q = 001.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ph1 | input | 1 | Phase one. The input latches are open while it is high. |
| ph2 | input | 1 | Phase two, which never overlaps ph1. The output latches are open while it is high. |
| clear_n | input | 1 | Low-true clear that forces the count to zero. |
| count_en | input | 1 | High-true count enable. |
| q | output | CNT_W (3) | Count value. Bit 0 is the LSB. |

## Verification
The bench builds the block with its default width of three bits, which makes the wrap code 6 and the unused code 7. At this width the full sequence fits within a few phase cycles. This lets the bench take the count through several complete wraps, hold it at an arbitrary code, and clear it from the middle of the sequence and from the wrap code. It also looks between the two phases, to confirm that nothing moves on ph1 alone and that a late input change is ignored.

// File: rtl/mod7_pkg.sv
package mod7_pkg;
   // code at which the truncated sequence wraps back to zero
   function automatic int unsigned wrap_code(input int unsigned w);
      return (1 << w) - 2;
   endfunction
endpackage

// File: rtl/mod7_latch.sv
module mod7_latch #(
   parameter bit RESET_VAL = 1'b0
) (
   input  logic en,
   input  logic d,
   output logic q
);
   always_latch begin
      if (en) q = d;
   end
endmodule

// File: rtl/mod7_tcell.sv
module mod7_tcell (
   input  logic ph1,
   input  logic ph2,
   input  logic tog,
   input  logic clr_n,
   output logic bit_q
);
   logic flipped, tog_sel, nxt, mid;

   // one inverter, two 2:1 muxes, two latches
   assign flipped = ~bit_q;
   assign tog_sel = tog   ? flipped : bit_q;
   assign nxt     = clr_n ? tog_sel : 1'b0;

   mod7_latch u_master (.en(ph1), .d(nxt), .q(mid));
   mod7_latch u_slave  (.en(ph2), .d(mid), .q(bit_q));
endmodule

// File: rtl/mod7_steer.sv
module mod7_steer #(
   parameter int unsigned CNT_W = 3
) (
   input  logic             count_en,
   input  logic [CNT_W-1:0] cur,
   output logic [CNT_W-1:0] tog
);
   import mod7_pkg::*;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(wrap_code(CNT_W));

   logic             at_last;
   logic [CNT_W-1:0] low_ones;

   assign at_last = (cur == LAST);

   generate
      for (genvar i = 0; i < CNT_W; i++) begin : g_bit
         if (i == 0) begin : g_lsb
            assign low_ones[i] = 1'b1;
            assign tog[i]      = count_en & ~at_last;
         end else begin : g_upper
            assign low_ones[i] = low_ones[i-1] & cur[i-1];
            assign tog[i]      = count_en & (low_ones[i] | (at_last & cur[i]));
         end
      end
   endgenerate
endmodule

// File: rtl/mod7_twophase_ctr.sv
module mod7_twophase_ctr #(
   parameter int unsigned CNT_W = 3
) (
   input  logic             ph1,
   input  logic             ph2,
   input  logic             clear_n,
   input  logic             count_en,
   output logic [CNT_W-1:0] q
);
   generate
      if (CNT_W < 2 || CNT_W > 16) begin : g_bad_width
         $error("mod7_twophase_ctr: CNT_W must be 2..16");
      end
   endgenerate

   logic [CNT_W-1:0] tog;

   mod7_steer #(.CNT_W(CNT_W)) u_steer (
      .count_en (count_en),
      .cur      (q),
      .tog      (tog)
   );

   generate
      for (genvar i = 0; i < CNT_W; i++) begin : g_cell
         mod7_tcell u_cell (
            .ph1   (ph1),
            .ph2   (ph2),
            .tog   (tog[i]),
            .clr_n (clear_n),
            .bit_q (q[i])
         );
      end
   endgenerate
endmodule

// File: rtl/mod7_twophase_chk.sv
module mod7_twophase_chk #(
   parameter int unsigned CNT_W = 3
) (
   input logic             ph1,
   input logic             ph2,
   input logic             clear_n,
   input logic             count_en,
   input logic [CNT_W-1:0] q
);
   import mod7_pkg::*;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(wrap_code(CNT_W));

   logic en_s = 1'b0, clr_s = 1'b1, primed = 1'b0;

   always_ff @(negedge ph1) begin
      en_s  <= count_en;
      clr_s <= clear_n;
   end

   always_ff @(negedge ph2) begin
      if (!clr_s) primed <= 1'b1;
   end

   always_comb begin
      a_r5_phases_apart: assert (!(ph1 && ph2));
   end

   // R4 / R1
   a_r4_clear_zero: assert property (@(negedge ph2) disable iff (!primed)
      !clr_s |-> q == '0);

   // R3
   a_r3_hold: assert property (@(negedge ph2) disable iff (!primed)
      (clr_s && !en_s) |-> q == $past(q));

   // R2
   a_r2_step: assert property (@(negedge ph2) disable iff (!primed)
      (clr_s && en_s) |-> q == (($past(q) == LAST) ? '0 : $past(q) + 1'b1));

   // R6
   a_r6_no_top_code: assert property (@(negedge ph2) disable iff (!primed)
      q != '1);
endmodule

bind mod7_twophase_ctr mod7_twophase_chk #(.CNT_W(CNT_W)) u_chk (
   .ph1(ph1), .ph2(ph2), .clear_n(clear_n), .count_en(count_en), .q(q)
);

// File: tb/mod7_twophase_ctr_test.sv
`timescale 1ns/1ps
module mod7_twophase_ctr_test;
   logic       ph1 = 1'b0, ph2 = 1'b0, clear_n = 1'b0, count_en = 1'b0;
   logic [2:0] q;
   int         vectors = 0, miscompares = 0, model = 0;
   bit         done = 1'b0;

   mod7_twophase_ctr #(.CNT_W(3)) uut (
      .ph1(ph1), .ph2(ph2), .clear_n(clear_n), .count_en(count_en), .q(q)
   );

   task automatic cmp(input string req, input int exp);
      vectors++;
      if (int'(q) != exp) begin
         miscompares++;
         $display("FAIL %s: q=%0d expected %0d at %0t", req, q, exp, $time);
      end
   endtask

   // one full 8 ns phase cycle; late = flip both inputs after ph1 closes
   task automatic step(input bit en_v, input bit clr_v, input bit late, input string req);
      count_en = en_v;
      clear_n  = clr_v;
      #1 ph1 = 1'b1;
      #2 ph1 = 1'b0;
      #1;
      if (late) begin
         count_en = ~en_v;
         clear_n  = ~clr_v;
      end
      cmp("R5", model);                // nothing moves on ph1 alone
      #1 ph2 = 1'b1;
      #2 ph2 = 1'b0;
      if (!clr_v)     model = 0;
      else if (en_v)  model = (model == 6) ? 0 : model + 1;
      #1 cmp(req, model);
   endtask

   initial begin
      #200000;
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog: q=%0d expected completion", q);
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      // R4: clear with enable low from power-up
      step(1'b0, 1'b0, 1'b0, "R4");
      // R8: first step from zero is 001
      step(1'b1, 1'b1, 1'b0, "R8");
      // R2, R6: run through three full wraps
      for (int i = 0; i < 20; i++) step(1'b1, 1'b1, 1'b0, "R2");
      // R3: hold at current code
      for (int i = 0; i < 4; i++) step(1'b0, 1'b1, 1'b0, "R3");
      // R1: clear overrides toggle mid-sequence
      step(1'b1, 1'b1, 1'b0, "R2");
      step(1'b1, 1'b0, 1'b0, "R1");
      // reach 6 then clear with enable high
      for (int i = 0; i < 6; i++) step(1'b1, 1'b1, 1'b0, "R2");
      cmp("R6", 6);
      step(1'b1, 1'b0, 1'b0, "R4");
      // R7: late input flips after ph1 must be ignored
      step(1'b1, 1'b1, 1'b1, "R7");
      step(1'b0, 1'b1, 1'b1, "R7");
      step(1'b1, 1'b0, 1'b1, "R7");
      step(1'b1, 1'b1, 1'b0, "R2");
      step(1'b1, 1'b1, 1'b0, "R2");
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule